// File: doc/BRIEF.md
# High-Speed Burst Sequencer for One Serial Data Lane

This block drives one data lane of a D-PHY style transmitter through a complete high-speed burst. While idle it holds the lane in the low-power stop state. When a byte is offered and the clock-lane sequencer reports that the clock is running, it steps the lane through the low-power request and bridge levels and a run of HS-0. It then sends a fixed leader byte and serializes the payload one bit per clock, in an order chosen at burst start. It closes the burst with a trail of the inverted final bit and a low-power exit gap before it returns to stop.

All entry, trail and exit durations come from a packed HS timing word, and the request duration comes from the low byte of a low-power timing word. Each field counts byte periods of eight clocks, and a zero field counts as one. Bytes arrive on a valid/ready handshake. Ready pulses once per byte, and a byte boundary without valid data ends the payload. A forced-stop input and a power-down input override everything else.

Top module: `dlane_hs_seq`

## Requirements
- R1: After reset the lane is at LP-11 (lp_p=1, lp_n=1) with hs_en=0, hs_bit=0, tx_ready=0 and status 4'b0100.
- R2: A burst starts only on a clock edge where tx_valid and clk_rdy are both 1. While clk_rdy is 0 the lane stays at LP-11 whatever tx_valid does.
- R3: Entry sequence: LP-01 (lp_p=0, lp_n=1) for lpx×8 cycles, where lpx is lp_tim[7:0]. Then LP-00 for prep×8 cycles (hs_tim[31:24]). Then HS-0 (hs_en=1, hs_bit=0, lp lines 0) for zero×8 cycles (hs_tim[23:16]). Every field value of 0 counts as 1.
- R4: After HS-0 the lane sends the leader byte 8'hB8 least significant bit first, which puts the bits 0,0,0,1,1,1,0,1 on the line, with hs_en=1.
- R5: Payload bytes follow the leader, one bit per cycle. If msb_first was 1 on the starting edge, bit 7 goes first; if it was 0, bit 0 goes first.
- R6: tx_ready is 1 for exactly one cycle per byte, on the eighth bit of the leader and of each payload byte. The byte on tx_data is taken on that edge if tx_valid is 1. If tx_valid is 0 the payload ends.
- R7: After the last bit the lane drives hs_en=1 with hs_bit equal to the inverse of that bit for trail×8 cycles (hs_tim[15:8]).
- R8: After the trail the lane drives LP-11 with hs_en=0 for exit×8 cycles (hs_tim[7:0]) and then returns to stop. Status bit 2 is 1 only in stop.
- R9: While force_stop is 1 the lane is at LP-11 in stop from the next cycle, with tx_ready 0, even when tx_valid and clk_rdy are 1.
- R10: While pwr_dn is 1 the lane drives lp_p=0, lp_n=0, hs_en=0, tx_ready=0 and status 0 from the next cycle, and it takes precedence over force_stop. One cycle after release the lane is back at LP-11 in stop.
- R11: status is {0, stop, 0, hs_en}: bits 3 and 1 always read 0 and bit 0 follows hs_en.
- R12: Only lp_tim[7:0] affects behaviour, and lp_tim[31:8] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_tim_i | input | 32 | Prep, zero, trail, exit counts in byte periods (high to low byte) |
| lp_tim_i | input | 32 | Low byte: LP-01 request count; upper bytes unused |
| msb_first_i | input | 1 | Bit order for the payload, sampled at burst start |
| force_stop_i | input | 1 | Hold lane in stop state |
| pwr_dn_i | input | 1 | Lane power-down |
| clk_rdy_i | input | 1 | Clock lane is running HS clock |
| tx_valid_i | input | 1 | Byte offered |
| tx_data_i | input | 8 | Payload byte |
| tx_ready_o | output | 1 | Byte taken on this edge when valid |
| lp_p_o | output | 1 | Low-power level, positive line |
| lp_n_o | output | 1 | Low-power level, negative line |
| hs_en_o | output | 1 | HS driver enable |
| hs_bit_o | output | 1 | Serial HS bit |
| status_o | output | 4 | {0, stop, 0, hs active} |

## Verification
The assertions assume that hs_tim and lp_tim do not change during a burst and that tx_valid, once raised, stays high until a ready pulse takes the byte. They also assume that a burst ends only by dropping tx_valid right after the last accepted byte. The bench follows these rules: it changes timing words and bit order only in stop, it updates data only in the cycle after each ready pulse, and it lowers tx_valid together with or before releasing force_stop or pwr_dn, so no new burst starts by accident.

// File: rtl/dlane_pkg.sv
package dlane_pkg;
    localparam int TFLD_W = 8;
    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int TMR_W  = TFLD_W + BIT_CW;
    localparam int TIM_W  = 4 * TFLD_W;
    localparam logic [BYTE_W-1:0] LEADER = 8'hB8;

    typedef enum logic [3:0] {
        ST_OFF, ST_STOP, ST_LPX, ST_PREP, ST_ZERO,
        ST_SYNC, ST_PAY, ST_TRAIL, ST_EXIT
    } lane_st_e;

    // field order matches the packed timing word, high byte first
    typedef struct packed {
        logic [TFLD_W-1:0] prep;
        logic [TFLD_W-1:0] zero;
        logic [TFLD_W-1:0] trail;
        logic [TFLD_W-1:0] leave;
    } hs_tim_t;

    typedef struct packed {
        logic lp_p;
        logic lp_n;
        logic hs_en;
        logic hs_bit;
    } line_t;

    // cycles minus one for a field counted in byte periods; zero acts as one
    function automatic logic [TMR_W-1:0] span_m1(input logic [TFLD_W-1:0] f);
        logic [TMR_W-1:0] n;
        n = (f == '0) ? TMR_W'(1) : TMR_W'(f);
        return (n << BIT_CW) - TMR_W'(1);
    endfunction
endpackage

// File: rtl/dlane_ctrl.sv
module dlane_ctrl
    import dlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hs_tim_t           hs_tim_i,
    input  logic [TFLD_W-1:0] lpx_i,
    input  logic              clk_rdy_i,
    input  logic              tx_valid_i,
    input  logic              force_stop_i,
    input  logic              pwr_dn_i,
    input  logic              byte_end_i,
    output lane_st_e          st_o,
    output logic              tx_ready_o,
    output logic              ld_sync_o,
    output logic              ld_data_o,
    output logic              start_o
);
    lane_st_e          st_q, st_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic              tmr_done, in_data, quiet;

    assign tmr_done   = (tmr_q == '0);
    assign in_data    = (st_q == ST_SYNC) || (st_q == ST_PAY);
    assign quiet      = force_stop_i || pwr_dn_i;
    assign tx_ready_o = in_data && byte_end_i && !quiet;
    assign ld_data_o  = tx_ready_o && tx_valid_i;
    assign start_o    = (st_q == ST_STOP) && tx_valid_i && clk_rdy_i && !quiet;
    assign ld_sync_o  = (st_q == ST_ZERO) && tmr_done && !quiet;
    assign st_o       = st_q;

    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_done ? tmr_q : tmr_q - TMR_W'(1);
        if (pwr_dn_i) begin
            st_d = ST_OFF;
        end else if (force_stop_i) begin
            st_d = ST_STOP;
        end else begin
            case (st_q)
                ST_OFF:  st_d = ST_STOP;
                ST_STOP: if (start_o) begin
                    st_d  = ST_LPX;
                    tmr_d = span_m1(lpx_i);
                end
                ST_LPX: if (tmr_done) begin
                    st_d  = ST_PREP;
                    tmr_d = span_m1(hs_tim_i.prep);
                end
                ST_PREP: if (tmr_done) begin
                    st_d  = ST_ZERO;
                    tmr_d = span_m1(hs_tim_i.zero);
                end
                ST_ZERO: if (tmr_done) st_d = ST_SYNC;
                ST_SYNC, ST_PAY: if (byte_end_i) begin
                    if (tx_valid_i) begin
                        st_d = ST_PAY;
                    end else begin
                        st_d  = ST_TRAIL;
                        tmr_d = span_m1(hs_tim_i.trail);
                    end
                end
                ST_TRAIL: if (tmr_done) begin
                    st_d  = ST_EXIT;
                    tmr_d = span_m1(hs_tim_i.leave);
                end
                ST_EXIT: if (tmr_done) st_d = ST_STOP;
                default: st_d = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_STOP;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    p_wait_clk_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && !clk_rdy_i) |=> (st_q == ST_STOP || st_q == ST_OFF));
    p_prep_after_lpx_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PREP) |-> ($past(st_q) == ST_LPX || $past(st_q) == ST_PREP));
    p_ready_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |=> !tx_ready_o);
    p_force_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (force_stop_i && !pwr_dn_i) |=> (st_q == ST_STOP && !tx_ready_o));
    p_pwr_dn_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_dn_i |=> (st_q == ST_OFF));
endmodule

// File: rtl/dlane_ser.sv
module dlane_ser
    import dlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_st_e          st_i,
    input  logic              ld_sync_i,
    input  logic              ld_data_i,
    input  logic              start_i,
    input  logic              msb_first_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              ser_bit_o,
    output logic              last_bit_o,
    output logic              byte_end_o
);
    logic [BYTE_W-1:0] sh_q;
    logic [BIT_CW-1:0] cnt_q;
    logic              ord_q, last_q, shifting, hi_first;

    assign shifting   = (st_i == ST_SYNC) || (st_i == ST_PAY);
    assign hi_first   = (st_i == ST_PAY) && ord_q;
    assign byte_end_o = (cnt_q == BIT_CW'(BYTE_W - 1));
    assign ser_bit_o  = hi_first ? sh_q[BYTE_W-1] : sh_q[0];
    assign last_bit_o = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            ord_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            if (start_i) ord_q <= msb_first_i;
            if (shifting) last_q <= ser_bit_o;
            if (ld_sync_i) begin
                sh_q  <= LEADER;
                cnt_q <= '0;
            end else if (ld_data_i) begin
                sh_q  <= data_i;
                cnt_q <= '0;
            end else if (shifting) begin
                sh_q  <= hi_first ? (sh_q << 1) : (sh_q >> 1);
                cnt_q <= cnt_q + BIT_CW'(1);
            end
        end
    end
endmodule

// File: rtl/dlane_drv.sv
module dlane_drv
    import dlane_pkg::*;
(
    input  lane_st_e   st_i,
    input  logic       ser_bit_i,
    input  logic       last_bit_i,
    output line_t      line_o,
    output logic [3:0] status_o
);
    always_comb begin
        line_o = '0;
        case (st_i)
            ST_STOP, ST_EXIT: begin
                line_o.lp_p = 1'b1;
                line_o.lp_n = 1'b1;
            end
            ST_LPX:  line_o.lp_n = 1'b1;
            ST_ZERO: line_o.hs_en = 1'b1;
            ST_SYNC, ST_PAY: begin
                line_o.hs_en  = 1'b1;
                line_o.hs_bit = ser_bit_i;
            end
            ST_TRAIL: begin
                line_o.hs_en  = 1'b1;
                line_o.hs_bit = ~last_bit_i;
            end
            default: line_o = '0;
        endcase
        status_o = {1'b0, (st_i == ST_STOP), 1'b0, line_o.hs_en};
    end
endmodule

// File: rtl/dlane_hs_seq.sv
module dlane_hs_seq
    import dlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TIM_W-1:0]  hs_tim_i,
    input  logic [TIM_W-1:0]  lp_tim_i,
    input  logic              msb_first_i,
    input  logic              force_stop_i,
    input  logic              pwr_dn_i,
    input  logic              clk_rdy_i,
    input  logic              tx_valid_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              tx_ready_o,
    output logic              lp_p_o,
    output logic              lp_n_o,
    output logic              hs_en_o,
    output logic              hs_bit_o,
    output logic [3:0]        status_o
);
    lane_st_e st;
    line_t    line;
    logic     ld_sync, ld_data, start, byte_end, ser_bit, last_bit;
    logic     unused_lp_hi;

    assign unused_lp_hi = ^lp_tim_i[TIM_W-1:TFLD_W];

    dlane_ctrl i_ctrl (
        .clk(clk), .rst(rst),
        .hs_tim_i(hs_tim_t'(hs_tim_i)), .lpx_i(lp_tim_i[TFLD_W-1:0]),
        .clk_rdy_i(clk_rdy_i), .tx_valid_i(tx_valid_i),
        .force_stop_i(force_stop_i), .pwr_dn_i(pwr_dn_i),
        .byte_end_i(byte_end), .st_o(st), .tx_ready_o(tx_ready_o),
        .ld_sync_o(ld_sync), .ld_data_o(ld_data), .start_o(start)
    );

    dlane_ser i_ser (
        .clk(clk), .rst(rst), .st_i(st),
        .ld_sync_i(ld_sync), .ld_data_i(ld_data), .start_i(start),
        .msb_first_i(msb_first_i), .data_i(tx_data_i),
        .ser_bit_o(ser_bit), .last_bit_o(last_bit), .byte_end_o(byte_end)
    );

    dlane_drv i_drv (
        .st_i(st), .ser_bit_i(ser_bit), .last_bit_i(last_bit),
        .line_o(line), .status_o(status_o)
    );

    assign lp_p_o   = line.lp_p;
    assign lp_n_o   = line.lp_n;
    assign hs_en_o  = line.hs_en;
    assign hs_bit_o = line.hs_bit;

    p_trail_inv_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRAIL && $past(st) != ST_TRAIL) |-> (hs_bit_o != $past(hs_bit_o)));
endmodule

// File: tb/test_dlane_hs_seq.sv
module test_dlane_hs_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hs_tim = '0, lp_tim = '0;
    logic        msb_first = 1'b0, force_stop = 1'b0, pwr_dn = 1'b0;
    logic        clk_rdy = 1'b0, tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, lp_p, lp_n, hs_en, hs_bit;
    logic [3:0]  status;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [7:0]  pay [8];

    localparam logic [8:0] IDLE = {1'b0, 4'b0100, 4'b1100};
    localparam logic [8:0] OFFV = 9'b0;

    always #5 clk = ~clk;

    dlane_hs_seq i_dlane_hs_seq (
        .clk(clk), .rst(rst), .hs_tim_i(hs_tim), .lp_tim_i(lp_tim),
        .msb_first_i(msb_first), .force_stop_i(force_stop), .pwr_dn_i(pwr_dn),
        .clk_rdy_i(clk_rdy), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
        .tx_ready_o(tx_ready), .lp_p_o(lp_p), .lp_n_o(lp_n), .hs_en_o(hs_en),
        .hs_bit_o(hs_bit), .status_o(status)
    );

    function automatic logic [8:0] obs();
        return {tx_ready, status, lp_p, lp_n, hs_en, hs_bit};
    endfunction

    function automatic logic [8:0] mk(input logic rdy, input logic stp, input logic lpp,
                                      input logic lpn, input logic hs, input logic b);
        return {rdy, 1'b0, stp, 1'b0, hs, lpp, lpn, hs, b};
    endfunction

    function automatic int sp(input logic [7:0] f);
        return (f == 0) ? 8 : int'(f) * 8;
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 during reset", obs(), IDLE);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 R11 after reset", obs(), IDLE);
    endtask

    task automatic t_no_clk();
        clk_rdy = 1'b0;
        tx_valid = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk("R2 waits for clk_rdy", obs(), IDLE);
        end
        tx_valid = 1'b0;
        clk_rdy = 1'b1;
        @(negedge clk);
        chk("R2 idle with clk_rdy", obs(), IDLE);
    endtask

    task automatic run_burst(input string tag, input logic [7:0] p, input logic [7:0] z,
                             input logic [7:0] t, input logic [7:0] e, input logic [7:0] lpx,
                             input logic [23:0] lp_hi, input logic msb, input int n);
        int a, b, c, s, py, tr, ex, k;
        bit adv;
        logic [8:0] exp;
        logic lastb;
        string req;
        @(negedge clk);
        hs_tim = {p, z, t, e};
        lp_tim = {lp_hi, lpx};
        msb_first = msb;
        tx_data = pay[0];
        tx_valid = 1'b1;
        a = sp(lpx); b = a + sp(p); c = b + sp(z); s = c + 8;
        py = s + 8 * n; tr = py + sp(t); ex = tr + sp(e);
        lastb = msb ? pay[n-1][0] : pay[n-1][7];
        k = 0; adv = 1'b0;
        for (int i = 0; i < ex + 3; i++) begin
            @(negedge clk);
            if (adv) begin
                k++;
                if (k < n) tx_data = pay[k]; else tx_valid = 1'b0;
                adv = 1'b0;
            end
            if (i < a) begin
                exp = mk(0, 0, 0, 1, 0, 0); req = "R3 R12 LP-01";
            end else if (i < b) begin
                exp = mk(0, 0, 0, 0, 0, 0); req = "R3 LP-00";
            end else if (i < c) begin
                exp = mk(0, 0, 0, 0, 1, 0); req = "R3 HS-0";
            end else if (i < s) begin
                exp = mk((i - c) == 7, 0, 0, 0, 1, 8'hB8 >> (i - c)); req = "R4 R6 leader";
            end else if (i < py) begin
                int q = i - s;
                logic [7:0] by = pay[q / 8];
                exp = mk((q % 8) == 7, 0, 0, 0, 1, msb ? by[7 - q % 8] : by[q % 8]);
                req = "R5 R6 payload";
            end else if (i < tr) begin
                exp = mk(0, 0, 0, 0, 1, ~lastb); req = "R7 trail";
            end else if (i < ex) begin
                exp = mk(0, 0, 1, 1, 0, 0); req = "R8 exit";
            end else begin
                exp = IDLE; req = "R8 R11 back to stop";
            end
            chk({tag, " ", req}, obs(), exp);
            if (exp[8]) adv = 1'b1;
        end
    endtask

    task automatic t_force();
        @(negedge clk);
        hs_tim = 32'h01010101; lp_tim = 32'h1;
        msb_first = 1'b1; tx_data = 8'h5A; tx_valid = 1'b1;
        repeat (36) @(negedge clk);
        force_stop = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 forced stop", obs(), IDLE);
        end
        tx_valid = 1'b0;
        force_stop = 1'b0;
        @(negedge clk);
        chk("R9 after release", obs(), IDLE);
    endtask

    task automatic t_pwr();
        @(negedge clk);
        pwr_dn = 1'b1; force_stop = 1'b1; tx_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R10 powered down", obs(), OFFV);
        end
        pwr_dn = 1'b0; force_stop = 1'b0; tx_valid = 1'b0;
        @(negedge clk);
        chk("R10 released to stop", obs(), IDLE);
    endtask

    initial begin
        t_reset();
        t_no_clk();
        pay[0] = 8'h3C; pay[1] = 8'hA1; pay[2] = 8'h80;
        run_burst("B1 msb", 8'd2, 8'd3, 8'd1, 8'd2, 8'd1, 24'hA5C3F0, 1'b1, 3);
        pay[0] = 8'hC6;
        run_burst("B2 lsb zero-fields", 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 24'h0, 1'b0, 1);
        pay[0] = 8'h01; pay[1] = 8'hFE;
        run_burst("B3 lsb", 8'd1, 8'd2, 8'd3, 8'd1, 8'd2, 24'hFFFFFF, 1'b0, 2);
        t_force();
        t_pwr();
        pay[0] = 8'h96;
        run_burst("B4 msb after power", 8'd1, 8'd1, 8'd2, 8'd1, 8'd1, 24'h123456, 1'b1, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule